// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block couples two eight-bit buses, A and B. Data can pass between them in either direction. Each direction has its own storage register with its own capture clock, and its own control input that decides whether the driven bus shows live data from the other side or the value held in that direction's register. A pair of enables with opposite polarity decides which bus, if any, the block drives.

Each bus is split into an input data port, an output data port and an output-enable port, so no tri-state nets appear inside the block. Pad logic outside the block joins them. A bus that is not driven shows zero on its output data port.

Because the registers capture on every rising edge of their own clocks, whatever the enables say, a bus can feed its register while the other bus is driven from stored data. When both buses are driven at once, each one carries stored data. Live data in that case would form a combinational loop through the pads.

Top module: `dual_reg_bus_xcvr`

## Requirements
- R1: When `en_a2b` = 1 and `en_b2a_n` = 1, `b_oe` is 1 and `a_oe` is 0.
- R2: When `en_a2b` = 0 and `en_b2a_n` = 0, `a_oe` is 1 and `b_oe` is 0.
- R3: When `en_a2b` = 0 and `en_b2a_n` = 1, neither bus is driven. Any undriven bus shows 0 on its output data port.
- R4: When `en_a2b` = 1 and `en_b2a_n` = 0, both buses are driven. `b_out` equals the A-side register and `a_out` equals the B-side register, whatever the select inputs are.
- R5: While only B is driven, `sel_a2b` = 0 puts live `a_in` on `b_out`, and `sel_a2b` = 1 puts the A-side register on `b_out`.
- R6: While only A is driven, `sel_b2a` = 0 puts live `b_in` on `a_out`, and `sel_b2a` = 1 puts the B-side register on `a_out`.
- R7: The A-side register loads `a_in` on every rising edge of `clk_a2b`, whatever the enables are. It holds its value when no edge occurs.
- R8: The B-side register loads `b_in` on every rising edge of `clk_b2a`, whatever the enables are. It holds its value when no edge occurs.
- R9: With `rst_n` low at a rising edge of a register's clock, that register is cleared to 0. Each register is cleared only by its own clock.
- R10: The live path is combinational. A change on `a_in` reaches `b_out` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a2b | input | 1 | Capture clock of the A-side register |
| clk_b2a | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Synchronous active-low clear, sampled on each register's own clock |
| en_a2b | input | 1 | Active-high enable for driving bus B |
| en_b2a_n | input | 1 | Active-low enable for driving bus A |
| sel_a2b | input | 1 | Source of B: 0 live A, 1 A-side register |
| sel_b2a | input | 1 | Source of A: 0 live B, 1 B-side register |
| a_in | input | 8 | Data received from bus A |
| a_out | output | 8 | Data driven onto bus A (zero when not driven) |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | 8 | Data received from bus B |
| b_out | output | 8 | Data driven onto bus B (zero when not driven) |
| b_oe | output | 1 | Bus B output enable |

## Verification
The hardest case to reach is a register capturing data while the ports cannot show its value at that moment. Examples are the A-side register loading while neither bus is driven, or while bus A is the driven side. The capture can only be seen afterwards. The stimulus first loads a register under one enable setting, then switches to a setting where that register appears on an output. It gates the capture clock off during the readback so that the value must have been held. Both-driven mode is entered with live selects to show that the forced stored path wins. A mid-run reset with only one clock running shows that the two clears are independent.

// File: rtl/hbt_pkg.sv
`timescale 1ns/1ps
package hbt_pkg;

    // source chosen for a driven bus
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    // decoded drive controls
    typedef struct packed {
        logic drive_a;
        logic drive_b;
        logic force_stored;
    } drive_ctl_t;

endpackage

// File: rtl/hbt_store_reg.sv
`timescale 1ns/1ps
module hbt_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] data;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.data = '0;
        end else begin
            state_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q = state_q.data;

    // R7 / R8: each edge loads the bus value present before it
    a_r7_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == $past(din)));

endmodule

// File: rtl/hbt_drive_decode.sv
`timescale 1ns/1ps
module hbt_drive_decode
    import hbt_pkg::*;
(
    input  logic       en_a2b,
    input  logic       en_b2a_n,
    output drive_ctl_t ctl
);

    always_comb begin
        ctl              = '0;
        ctl.drive_b      = en_a2b;
        ctl.drive_a      = ~en_b2a_n;
        ctl.force_stored = en_a2b & ~en_b2a_n;
    end

    // R4: stored data is forced exactly when both buses are driven
    always_comb begin
        a_r4_force_consistent: assert (ctl.force_stored == (ctl.drive_a & ctl.drive_b));
    end

endmodule

// File: rtl/hbt_bus_mux.sv
`timescale 1ns/1ps
module hbt_bus_mux
    import hbt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         drive,
    input  logic         force_stored,
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out,
    output logic         oe
);

    src_sel_e src;

    always_comb begin
        if (force_stored || sel) begin
            src = SRC_STORED;
        end else begin
            src = SRC_LIVE;
        end
    end

    always_comb begin
        out = '0;
        if (drive) begin
            out = (src == SRC_STORED) ? stored : live;
        end
    end

    assign oe = drive;

endmodule

// File: rtl/dual_reg_bus_xcvr.sv
`timescale 1ns/1ps
module dual_reg_bus_xcvr
    import hbt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_a2b,
    input  logic         clk_b2a,
    input  logic         rst_n,
    input  logic         en_a2b,
    input  logic         en_b2a_n,
    input  logic         sel_a2b,
    input  logic         sel_b2a,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    drive_ctl_t   ctl;
    logic [W-1:0] a_store_q;
    logic [W-1:0] b_store_q;

    hbt_store_reg #(.W(W)) u_a_store (
        .clk  (clk_a2b),
        .rst_n(rst_n),
        .din  (a_in),
        .q    (a_store_q)
    );

    hbt_store_reg #(.W(W)) u_b_store (
        .clk  (clk_b2a),
        .rst_n(rst_n),
        .din  (b_in),
        .q    (b_store_q)
    );

    hbt_drive_decode u_dec (
        .en_a2b  (en_a2b),
        .en_b2a_n(en_b2a_n),
        .ctl     (ctl)
    );

    hbt_bus_mux #(.W(W)) u_mux_b (
        .drive       (ctl.drive_b),
        .force_stored(ctl.force_stored),
        .sel         (sel_a2b),
        .live        (a_in),
        .stored      (a_store_q),
        .out         (b_out),
        .oe          (b_oe)
    );

    hbt_bus_mux #(.W(W)) u_mux_a (
        .drive       (ctl.drive_a),
        .force_stored(ctl.force_stored),
        .sel         (sel_b2a),
        .live        (b_in),
        .stored      (b_store_q),
        .out         (a_out),
        .oe          (a_oe)
    );

    a_r1_b_only: assert property (@(posedge clk_a2b) disable iff (!rst_n)
        (en_a2b && en_b2a_n) |-> (b_oe && !a_oe));

    a_r2_a_only: assert property (@(posedge clk_a2b) disable iff (!rst_n)
        (!en_a2b && !en_b2a_n) |-> (a_oe && !b_oe));

    a_r3_idle_zero: assert property (@(posedge clk_a2b) disable iff (!rst_n)
        (!a_oe |-> (a_out == '0)) and (!b_oe |-> (b_out == '0)));

    a_r4_both_stored: assert property (@(posedge clk_a2b) disable iff (!rst_n)
        (a_oe && b_oe) |-> ((b_out == a_store_q) && (a_out == b_store_q)));

    a_r5_live_b: assert property (@(posedge clk_a2b) disable iff (!rst_n)
        (b_oe && !a_oe && !sel_a2b) |-> (b_out == a_in));

endmodule

// File: tb/dual_reg_bus_xcvr_test.sv
`timescale 1ns/1ps
module dual_reg_bus_xcvr_test;

    typedef struct {
        logic [7:0] a_out;
        logic       a_oe;
        logic [7:0] b_out;
        logic       b_oe;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic gate_a = 1'b0, gate_b = 1'b0;
    logic clk_a2b, clk_b2a;
    logic rst_n = 1'b0;
    logic en_a2b = 1'b0, en_b2a_n = 1'b1;
    logic sel_a2b = 1'b0, sel_b2a = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [7:0] a_out, b_out;
    logic a_oe, b_oe;

    logic [7:0] mdl_a = '0, mdl_b = '0;
    exp_t sb_q[$];
    event chk_ev;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign clk_a2b = clk & gate_a;
    assign clk_b2a = clk & gate_b;

    dual_reg_bus_xcvr uut (
        .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .rst_n(rst_n),
        .en_a2b(en_a2b), .en_b2a_n(en_b2a_n),
        .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // expected outputs from the requirements
    function automatic exp_t predict(string tag);
        exp_t e;
        logic both;
        e.b_oe = en_a2b;
        e.a_oe = !en_b2a_n;
        both   = e.a_oe && e.b_oe;
        e.b_out = e.b_oe ? ((sel_a2b || both) ? mdl_a : a_in) : 8'h00;
        e.a_out = e.a_oe ? ((sel_b2a || both) ? mdl_b : b_in) : 8'h00;
        e.tag = tag;
        return e;
    endfunction

    // driver: one clock step, then push expectation
    task automatic step(input logic ga, input logic gb, input logic rn,
                        input logic eab, input logic eban,
                        input logic sab, input logic sba,
                        input logic [7:0] ain, input logic [7:0] bin,
                        input string tag);
        @(negedge clk);
        gate_a = ga; gate_b = gb; rst_n = rn;
        en_a2b = eab; en_b2a_n = eban; sel_a2b = sab; sel_b2a = sba;
        a_in = ain; b_in = bin;
        @(posedge clk);
        if (ga) mdl_a = rn ? ain : 8'h00;
        if (gb) mdl_b = rn ? bin : 8'h00;
        #3;
        sb_q.push_back(predict(tag));
        -> chk_ev;
    endtask

    // driver without clock edge: combinational change only (R10)
    task automatic comb_poke(input logic [7:0] ain, input string tag);
        @(negedge clk);
        gate_a = 1'b0; gate_b = 1'b0;
        a_in = ain;
        #2;
        sb_q.push_back(predict(tag));
        -> chk_ev;
    endtask

    // monitor
    always @(chk_ev) begin
        exp_t e;
        #1;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_cmp++;
            if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
                n_bad++;
                $display("FAIL %s: got a_oe=%0b a_out=%h b_oe=%0b b_out=%h, expected a_oe=%0b a_out=%h b_oe=%0b b_out=%h",
                         e.tag, a_oe, a_out, b_oe, b_out, e.a_oe, e.a_out, e.b_oe, e.b_out);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R9 reset state: both driven shows both stored registers
        step(1, 1, 0, 1, 0, 0, 0, 8'hAA, 8'h55, "R9 reset clears both");
        // R1 R5 live A onto B, R7 capture
        step(1, 0, 1, 1, 1, 0, 0, 8'h5A, 8'h00, "R1 R5 live a_in on B");
        // R5 stored, R7 hold with clock gated
        step(0, 0, 1, 1, 1, 1, 0, 8'h33, 8'h00, "R5 R7 stored A held");
        // R2 R6 live B onto A, R8 capture
        step(0, 1, 1, 0, 0, 0, 0, 8'h00, 8'hC3, "R2 R6 live b_in on A");
        step(0, 0, 1, 0, 0, 0, 1, 8'h00, 8'h11, "R6 R8 stored B held");
        // R3 idle, R7 capture while idle
        step(1, 0, 1, 0, 1, 0, 0, 8'h77, 8'h99, "R3 neither driven");
        step(0, 0, 1, 1, 1, 1, 0, 8'h01, 8'h99, "R7 capture during idle");
        // R4 both driven with live selects
        step(0, 0, 1, 1, 0, 0, 0, 8'hE0, 8'h0E, "R4 both driven stored");
        // R8 capture while A is the driven side
        step(0, 1, 1, 0, 0, 1, 1, 8'h00, 8'h6B, "R8 capture while A driven");
        step(0, 0, 1, 1, 0, 1, 1, 8'hFF, 8'hFF, "R4 R8 readback both driven");
        // R7 capture while B driven from stored A
        step(1, 0, 1, 1, 1, 1, 0, 8'h3C, 8'h00, "R7 capture while B stored");
        // R10 combinational live path
        step(0, 0, 1, 1, 1, 0, 0, 8'h10, 8'h00, "R10 live base");
        comb_poke(8'h81, "R10 live change no edge");
        comb_poke(8'h7E, "R10 live change again");
        // R9 reset only on A clock: A cleared, B kept
        step(1, 0, 0, 1, 0, 0, 0, 8'hAB, 8'hCD, "R9 reset A only");
        step(0, 0, 1, 1, 0, 1, 1, 8'h00, 8'h00, "R9 B survives");
        // sweep a few values through both directions
        for (int i = 0; i < 8; i++) begin
            step(1, 1, 1, 1, 1, 0, 0, 8'(i * 37 + 3), 8'(i * 91 + 5), "R1 R7 R8 sweep");
            step(0, 0, 1, 0, 0, 1, 1, 8'(i * 13), 8'(i * 7), "R2 R6 sweep stored");
        end
        step(0, 0, 1, 0, 1, 1, 1, 8'hFF, 8'hFF, "R3 final idle");
        #20;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule